// File: doc/BRIEF.md
# Capture/Compare Timer with Power and Debug Gating

A free-running 16-bit up-counter, clocked through a power-of-two prescaler from the internal clock, serves two channels. Each channel is set up separately as an input capture, which latches the count on a selected pin edge, or as an output compare, which drives its pin when the count reaches the channel value. The counter wraps to zero after a programmable modulo value and raises an overflow flag. A small synchronous register bus reads and writes configuration, counter and channel values.

Three system controls gate the timer in different ways. In wait mode the timer keeps running but the bus cannot reach it, and any enabled interrupt request raises a wake output. In stop mode every piece of state is frozen unchanged and the timer resumes from it afterwards. While the debug-break input is high the counter holds and capture edges are dropped. A software halt bit holds the counter so that power can be saved before wait mode.

Top module: `cc_timer`

## Requirements
- R1: After reset CTRL (address 0) reads 0x0008 (halt set, divide select 0, overflow interrupt off), MOD (address 3) reads 0xFFFF, COUNT (address 2) reads 0, and ch_out, ch_irq, ovf_irq and wake are all low.
- R2: CTRL[2:0] selects the prescaler divide as 2 to the power of the field value, with 7 treated as 64; the counter advances once for every divide-count of cycles in which it is allowed to run.
- R3: On an advance from a count equal to MOD the counter goes to zero and STAT[0] (address 1) is set; ovf_irq is STAT[0] AND CTRL[4].
- R4: While CTRL[3] is 1 the counter and the prescaler phase do not change.
- R5: Any write to COUNT sets the counter and the prescaler phase to zero.
- R6: A channel with config bit 0 clear captures: config bits [2:1] pick the edge (01 rising, 10 falling, 11 either, 00 none); on that edge the current count is stored in the channel value register and the channel flag is set; other edges are ignored. Channel n has config at address 4+2n, value at 5+2n, flag at STAT[1+n].
- R7: A channel with config bit 0 set compares: when the counter advances from a count equal to the channel value, the pin is set (01), cleared (10) or toggled (11) in that same cycle and the channel flag is set.
- R8: ch_irq[n] is the channel flag AND config bit 3; writing 1 to a STAT bit clears that flag.
- R9: In wait mode the counter and channels keep running, bus_rdata reads 0 and bus writes have no effect.
- R10: In stop mode the counter, prescaler, flags, channel values and pins are held unchanged, the bus is blocked as in R9, and counting continues from the held state afterwards.
- R11: While dbg_break is high the counter does not advance and capture edges are ignored.
- R12: wake is high exactly when any enabled overflow or channel interrupt request is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wait_mode | input | 1 | Wait-mode indication |
| stop_mode | input | 1 | Stop-mode indication |
| dbg_break | input | 1 | Debug-break indication |
| ch_in | input | 2 | Channel capture pins |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| ch_out | output | 2 | Channel compare pins |
| ch_irq | output | 2 | Per-channel interrupt requests |
| ovf_irq | output | 1 | Overflow interrupt request |
| wake | output | 1 | Wake request for wait mode |

## Verification
Register writes land on the rising edge where bus_sel and bus_wr are high, and reads are combinational, so the bench drives at the falling edge and reads one time unit later. A counting window spans from the edge after the write clearing CTRL[3] through the edge of the write setting it again, so a window of N edges yields N divided by the divide value. A capture edge driven at a falling edge lands in the value register and flag at the next rising edge and is read at the following falling edge; compare pins and flags change on the same edge as the advance from the matching count. Interrupt and wake outputs follow the flags combinationally and are sampled at the falling edge after the edge that changes the flag.

// File: rtl/cct_pkg.sv
// Shared constants and types of the capture/compare timer.
// Assumes: register addresses are word indices on a small synchronous bus.
package cct_pkg;

    localparam int ADR_CTRL    = 0;
    localparam int ADR_STAT    = 1;
    localparam int ADR_COUNT   = 2;
    localparam int ADR_MOD     = 3;
    localparam int ADR_CH_BASE = 4;

    // Edge selection in capture mode, pin action in compare mode.
    typedef enum logic [1:0] {
        ACT_NONE     = 2'b00,
        ACT_RISE_SET = 2'b01,
        ACT_FALL_CLR = 2'b10,
        ACT_BOTH_TGL = 2'b11
    } act_t;

    // Channel configuration word: [3] irq enable, [2:1] action, [0] compare mode.
    typedef struct packed {
        logic ie;
        act_t act;
        logic is_cmp;
    } ch_cfg_t;

endpackage

// File: rtl/cct_prescaler.sv
// Power-of-two clock-enable divider for the timer counter.
// Assumes: sel values above MAX_LOG clamp to the largest divide.
module cct_prescaler #(
    parameter int SEL_W   = 3,
    parameter int MAX_LOG = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic [MAX_LOG-1:0] pc_q;
    logic [MAX_LOG-1:0] mask;

    // Build the low-bit mask whose all-ones value marks the last phase.
    always_comb begin
        mask = '0;
        for (int i = 0; i < MAX_LOG; i++) begin
            if (i < int'(sel)) mask[i] = 1'b1;
        end
    end

    assign tick = run && !clr && ((pc_q & mask) == mask);

    // Advance the phase counter while running; restart after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       pc_q <= '0;
        else if (clr)     pc_q <= '0;
        else if (tick)    pc_q <= '0;
        else if (run)     pc_q <= pc_q + 1'b1;
    end

endmodule

// File: rtl/cct_counter.sv
// Modulo up-counter advanced by the prescaler tick.
// Assumes: clr has priority over counting and suppresses the wrap pulse.
module cct_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clr,
    input  logic [W-1:0] modulo,
    output logic [W-1:0] cnt,
    output logic         wrap
);

    logic [W-1:0] cnt_q;

    assign cnt  = cnt_q;
    assign wrap = tick && !clr && (cnt_q == modulo);

    // Count up on each tick, returning to zero after the modulo value.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr)   cnt_q <= '0;
        else if (wrap)  cnt_q <= '0;
        else if (tick)  cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/cct_channel.sv
// One timer channel: edge capture or count compare with pin action.
// Assumes: pin_in is already synchronous to clk; active is low in stop mode.
module cct_channel
    import cct_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic         cap_ok,
    input  logic         tick,
    input  logic [W-1:0] cnt,
    input  ch_cfg_t      cfg,
    input  logic         val_we,
    input  logic [W-1:0] val_wd,
    input  logic         pin_in,
    output logic [W-1:0] val,
    output logic         evt,
    output logic         pin_out
);

    logic         prev_q;
    logic [W-1:0] val_q;
    logic         pin_q;
    logic         rise;
    logic         fall;
    logic         edge_hit;
    logic         cap_evt;
    logic         cmp_evt;

    assign rise = pin_in && !prev_q;
    assign fall = !pin_in && prev_q;

    // Match the observed edge against the selected edge kind.
    always_comb begin
        unique case (cfg.act)
            ACT_RISE_SET: edge_hit = rise;
            ACT_FALL_CLR: edge_hit = fall;
            ACT_BOTH_TGL: edge_hit = rise || fall;
            default:      edge_hit = 1'b0;
        endcase
    end

    assign cap_evt = !cfg.is_cmp && cap_ok && edge_hit;
    assign cmp_evt = cfg.is_cmp && tick && (cnt == val_q);
    assign evt     = cap_evt || cmp_evt;
    assign val     = val_q;
    assign pin_out = pin_q;

    // Remember the previous pin level unless the block is frozen.
    always_ff @(posedge clk) begin
        if (!rst_n)      prev_q <= 1'b0;
        else if (active) prev_q <= pin_in;
    end

    // Latch the count on capture; otherwise take bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       val_q <= '0;
        else if (cap_evt) val_q <= cnt;
        else if (val_we)  val_q <= val_wd;
    end

    // Apply the compare action to the output pin on a match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else if (cmp_evt) begin
            unique case (cfg.act)
                ACT_RISE_SET: pin_q <= 1'b1;
                ACT_FALL_CLR: pin_q <= 1'b0;
                ACT_BOTH_TGL: pin_q <= !pin_q;
                default:      pin_q <= pin_q;
            endcase
        end
    end

endmodule

// File: rtl/cc_timer.sv
// Capture/compare timer top: register bus, prescaler, counter, channels,
// flags and interrupt requests, gated by wait, stop and debug-break inputs.
// Assumes: single clock domain; bus reads are combinational.
module cc_timer
    import cct_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int N_CH    = 2,
    parameter int SEL_W   = 3,
    parameter int MAX_LOG = 6,
    localparam int N_REG  = ADR_CH_BASE + 2 * N_CH,
    localparam int ADDR_W = $clog2(N_REG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wait_mode,
    input  logic              stop_mode,
    input  logic              dbg_break,
    input  logic [N_CH-1:0]   ch_in,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [N_CH-1:0]   ch_out,
    output logic [N_CH-1:0]   ch_irq,
    output logic              ovf_irq,
    output logic              wake
);

    localparam int FLAG_W = 1 + N_CH;
    localparam int CFG_W  = $bits(ch_cfg_t);

    logic [SEL_W-1:0]  sel_q;
    logic              halt_q;
    logic              ovf_ie_q;
    logic [CNT_W-1:0]  mod_q;
    logic [FLAG_W-1:0] flags_q;
    ch_cfg_t           cfg_q [N_CH];

    logic              acc;
    logic              we;
    logic              run;
    logic              tick;
    logic              cnt_clr;
    logic [CNT_W-1:0]  cnt;
    logic              wrap;
    logic [N_CH-1:0]   ch_evt;
    logic [CNT_W-1:0]  ch_val [N_CH];
    logic [FLAG_W-1:0] flag_set;
    logic [FLAG_W-1:0] flag_clr;

    assign acc     = bus_sel && !wait_mode && !stop_mode;
    assign we      = acc && bus_wr;
    assign run     = !halt_q && !stop_mode && !dbg_break;
    assign cnt_clr = we && (bus_addr == ADDR_W'(ADR_COUNT));

    cct_prescaler #(.SEL_W(SEL_W), .MAX_LOG(MAX_LOG)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clr   (cnt_clr),
        .sel   (sel_q),
        .tick  (tick)
    );

    cct_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .clr    (cnt_clr),
        .modulo (mod_q),
        .cnt    (cnt),
        .wrap   (wrap)
    );

    genvar g;
    generate
        for (g = 0; g < N_CH; g++) begin : g_ch
            cct_channel #(.W(CNT_W)) u_ch (
                .clk     (clk),
                .rst_n   (rst_n),
                .active  (!stop_mode),
                .cap_ok  (!stop_mode && !dbg_break),
                .tick    (tick),
                .cnt     (cnt),
                .cfg     (cfg_q[g]),
                .val_we  (we && (bus_addr == ADDR_W'(ADR_CH_BASE + 2 * g + 1))),
                .val_wd  (bus_wdata),
                .pin_in  (ch_in[g]),
                .val     (ch_val[g]),
                .evt     (ch_evt[g]),
                .pin_out (ch_out[g])
            );
            assign ch_irq[g] = flags_q[1 + g] && cfg_q[g].ie;
        end
    endgenerate

    assign ovf_irq = flags_q[0] && ovf_ie_q;
    assign wake    = ovf_irq || (|ch_irq);

    // Control register: divide select, software halt, overflow irq enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= '0;
            halt_q   <= 1'b1;
            ovf_ie_q <= 1'b0;
        end else if (we && (bus_addr == ADDR_W'(ADR_CTRL))) begin
            sel_q    <= bus_wdata[SEL_W-1:0];
            halt_q   <= bus_wdata[SEL_W];
            ovf_ie_q <= bus_wdata[SEL_W+1];
        end
    end

    // Modulo register: last count before the wrap to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    mod_q <= '1;
        else if (we && (bus_addr == ADDR_W'(ADR_MOD))) mod_q <= bus_wdata;
    end

    // Channel configuration registers.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N_CH; i++) begin
            if (!rst_n)
                cfg_q[i] <= '0;
            else if (we && (bus_addr == ADDR_W'(ADR_CH_BASE + 2 * i)))
                cfg_q[i] <= ch_cfg_t'(bus_wdata[CFG_W-1:0]);
        end
    end

    assign flag_set = {ch_evt, wrap};
    assign flag_clr = (we && (bus_addr == ADDR_W'(ADR_STAT))) ? bus_wdata[FLAG_W-1:0] : '0;

    // Event flags: set by events, cleared by writing ones; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~flag_clr) | flag_set;
    end

    // Read multiplexer; returns zero when the bus is not granted.
    always_comb begin
        bus_rdata = '0;
        if (acc) begin
            if (bus_addr == ADDR_W'(ADR_CTRL))
                bus_rdata = CNT_W'({ovf_ie_q, halt_q, sel_q});
            else if (bus_addr == ADDR_W'(ADR_STAT))
                bus_rdata = CNT_W'(flags_q);
            else if (bus_addr == ADDR_W'(ADR_COUNT))
                bus_rdata = cnt;
            else if (bus_addr == ADDR_W'(ADR_MOD))
                bus_rdata = mod_q;
            for (int i = 0; i < N_CH; i++) begin
                if (bus_addr == ADDR_W'(ADR_CH_BASE + 2 * i))
                    bus_rdata = CNT_W'(cfg_q[i]);
                else if (bus_addr == ADDR_W'(ADR_CH_BASE + 2 * i + 1))
                    bus_rdata = ch_val[i];
            end
        end
    end

endmodule

// File: rtl/cct_checker.sv
// Temporal checks on the timer, attached to every cc_timer instance.
// Assumes: sampled on the rising clock edge, inactive during reset.
module cct_checker #(
    parameter int CNT_W  = 16,
    parameter int FLAG_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wait_mode,
    input logic              stop_mode,
    input logic              dbg_break,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic              tick,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  mod_val,
    input logic [FLAG_W-1:0] flags,
    input logic              wake
);

    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_mode |=> ($stable(cnt) && $stable(flags))); // R10

    AST_BREAK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_break |=> $stable(cnt)); // R11

    AST_BREAK_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_break |=> ((flags[FLAG_W-1:1] & ~$past(flags[FLAG_W-1:1])) == '0)); // R11

    AST_WAIT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_mode && bus_sel && bus_wr) |=> $stable(mod_val)); // R9

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (cnt == mod_val)) |=> ((cnt == '0) && flags[0])); // R3

    AST_WAKE_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (flags != '0)); // R12

endmodule

bind cc_timer cct_checker #(.CNT_W(CNT_W), .FLAG_W(1 + N_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wait_mode (wait_mode),
    .stop_mode (stop_mode),
    .dbg_break (dbg_break),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .tick      (tick),
    .cnt       (cnt),
    .mod_val   (mod_q),
    .flags     (flags_q),
    .wake      (wake)
);

// File: tb/sim_cc_timer.sv
// Self-checking bench for cc_timer: prescaler vector table, then directed tests.
module sim_cc_timer;

    localparam int A_CTRL = 0, A_STAT = 1, A_COUNT = 2, A_MOD = 3;
    localparam int A_C0CFG = 4, A_C0VAL = 5, A_C1CFG = 6, A_C1VAL = 7;

    // {divide select, running edges, expected count}
    localparam logic [31:0] VEC [7] = '{
        {8'd0, 8'd10,  16'd10},
        {8'd1, 8'd10,  16'd5},
        {8'd2, 8'd21,  16'd5},
        {8'd3, 8'd64,  16'd8},
        {8'd4, 8'd33,  16'd2},
        {8'd6, 8'd130, 16'd2},
        {8'd7, 8'd128, 16'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wait_mode = 1'b0, stop_mode = 1'b0, dbg_break = 1'b0;
    logic [1:0]  ch_in = 2'b00;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  ch_out, ch_irq;
    logic        ovf_irq, wake;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cc_timer u0 (
        .clk(clk), .rst_n(rst_n), .wait_mode(wait_mode), .stop_mode(stop_mode),
        .dbg_break(dbg_break), .ch_in(ch_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ch_out(ch_out), .ch_irq(ch_irq), .ovf_irq(ovf_irq), .wake(wake)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h exp %0h", tag, got, exp);
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge.
    task automatic wr(input int a, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'(a);
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // Run the counter for exactly 'runs' rising edges, then halt it.
    task automatic run_for(input logic [2:0] sel, input int runs, input logic ie);
        wr(A_CTRL, {11'd0, ie, 1'b0, sel});
        repeat (runs - 1) @(negedge clk);
        wr(A_CTRL, {11'd0, ie, 1'b1, sel});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d, d2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, d);  check("R1 ctrl", d, 16'h0008);
        rd(A_MOD, d);   check("R1 mod", d, 16'hFFFF);
        rd(A_COUNT, d); check("R1 count", d, 16'h0000);
        check("R1 pins/irqs", {ch_out, ch_irq, ovf_irq, wake}, 6'b0);

        // R2 prescaler vector table, R5 count clear before each run
        for (int i = 0; i < 7; i++) begin
            wr(A_COUNT, 16'h0);
            run_for(VEC[i][26:24], int'(VEC[i][23:16]), 1'b0);
            rd(A_COUNT, d);
            check($sformatf("R2 divide sel %0d", VEC[i][31:24]), d, VEC[i][15:0]);
        end

        // R4 halted counter holds
        rd(A_COUNT, d);
        repeat (5) @(negedge clk);
        rd(A_COUNT, d2);
        check("R4 halt holds", d2, d);
        // R5 write to COUNT clears
        wr(A_COUNT, 16'h1234);
        rd(A_COUNT, d); check("R5 clear", d, 16'h0);

        // R6 capture: ch0 rising with irq enabled
        run_for(3'd0, 7, 1'b0);
        wr(A_C0CFG, 16'h000A);
        ch_in[0] = 1'b1;
        @(negedge clk);
        rd(A_C0VAL, d); check("R6 ch0 rising value", d, 16'd7);
        rd(A_STAT, d);  check("R6 ch0 flag", d, 16'h0002);
        check("R8 ch_irq set", ch_irq, 2'b01);
        check("R12 wake on ch irq", wake, 1'b1);
        wr(A_STAT, 16'h0002);
        check("R8 ch_irq cleared", {ch_irq, wake}, 3'b000);

        // R6 ch1 falling: rising edge ignored
        wr(A_C1CFG, 16'h0004);
        ch_in[1] = 1'b1;
        @(negedge clk);
        rd(A_STAT, d);  check("R6 rise ignored in falling mode", d, 16'h0);
        rd(A_C1VAL, d); check("R6 value untouched", d, 16'h0);
        ch_in[1] = 1'b0;
        @(negedge clk);
        rd(A_STAT, d);  check("R6 ch1 falling flag", d, 16'h0004);
        rd(A_C1VAL, d); check("R6 ch1 falling value", d, 16'd7);
        wr(A_STAT, 16'h0004);
        // R6 either-edge on ch0
        wr(A_C0CFG, 16'h0006);
        ch_in[0] = 1'b0;
        @(negedge clk);
        rd(A_STAT, d);  check("R6 either edge", d, 16'h0002);
        wr(A_STAT, 16'h0002);

        // R11 break: no counting, no capture
        wr(A_COUNT, 16'h0);
        dbg_break = 1'b1;
        wr(A_CTRL, 16'h0000);
        repeat (3) @(negedge clk);
        ch_in[0] = 1'b1;
        repeat (3) @(negedge clk);
        wr(A_CTRL, 16'h0008);
        dbg_break = 1'b0;
        @(negedge clk);
        rd(A_COUNT, d); check("R11 break count", d, 16'h0);
        rd(A_STAT, d);  check("R11 break capture", d, 16'h0);

        // R7 compare: ch0 set at 2, ch1 toggle at 3
        wr(A_C0CFG, 16'h0003); wr(A_C0VAL, 16'd2);
        wr(A_C1CFG, 16'h0007); wr(A_C1VAL, 16'd3);
        wr(A_COUNT, 16'h0);
        run_for(3'd0, 4, 1'b0);
        check("R7 set and toggle", ch_out, 2'b11);
        rd(A_STAT, d);  check("R7 compare flags", d, 16'h0006);
        wr(A_C0CFG, 16'h0005); wr(A_C0VAL, 16'd5);
        wr(A_STAT, 16'h0006);
        run_for(3'd0, 2, 1'b0);
        check("R7 clear action", ch_out, 2'b10);
        rd(A_COUNT, d); check("R7 count after", d, 16'd6);

        // R3 modulo wrap and overflow irq
        wr(A_C0CFG, 16'h0); wr(A_C1CFG, 16'h0);
        wr(A_STAT, 16'h0007);
        wr(A_MOD, 16'd5);
        wr(A_COUNT, 16'h0);
        run_for(3'd0, 6, 1'b1);
        rd(A_COUNT, d); check("R3 wrapped to zero", d, 16'h0);
        rd(A_STAT, d);  check("R3 overflow flag", d, 16'h0001);
        check("R3 ovf_irq", ovf_irq, 1'b1);
        check("R12 wake on ovf", wake, 1'b1);
        wr(A_STAT, 16'h0001);
        check("R8 ovf cleared", {ovf_irq, wake}, 2'b00);
        wr(A_MOD, 16'hFFFF);

        // R9 wait mode: counting continues, bus blocked
        wr(A_COUNT, 16'h0);
        wr(A_CTRL, 16'h0000);
        wait_mode = 1'b1;
        wr(A_MOD, 16'd7);
        rd(A_MOD, d); check("R9 read blocked", d, 16'h0);
        repeat (8) @(negedge clk);
        wait_mode = 1'b0;
        wr(A_CTRL, 16'h0008);
        rd(A_COUNT, d); check("R9 counts in wait", d, 16'd10);
        rd(A_MOD, d);   check("R9 write ignored", d, 16'hFFFF);

        // R10 stop mode: frozen, resumes
        wr(A_COUNT, 16'h0);
        wr(A_CTRL, 16'h0000);
        stop_mode = 1'b1;
        repeat (9) @(negedge clk);
        rd(A_COUNT, d); check("R10 read blocked", d, 16'h0);
        check("R10 pins held", ch_out, 2'b10);
        stop_mode = 1'b0;
        wr(A_CTRL, 16'h0008);
        rd(A_COUNT, d); check("R10 resumes from held count", d, 16'd1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule